// File: doc/BRIEF.md
# UART Receive Buffer with Automatic Request-to-Send

This block is the receive side of a UART that follows the serial bit sampler. The sampler reports two events: a start transition has been seen (`start_det`), and the first stop bit of a frame has been sampled (`frame_done`). Along with the second event it hands over the received byte and an extra address bit, which tells an address word from a data word on a multi-drop line. Each finished word goes into an eight-entry first-in first-out store, and the host removes words from it with `pop`.

From the fill level the block derives a threshold status that the host can use to read several words per service. It also tracks whether a reception is in progress. It raises a sticky overrun flag when a word arrives and no entry is free, and it keeps a sticky flag that records that an address word has arrived.

The block drives the request-to-send line towards the remote transmitter. In automatic mode the line is released with hysteresis: it is withdrawn only when a further start bit arrives while the buffer already holds a watermark of words, and it is granted again as soon as reads take the level below that watermark. In manual mode the line follows a control bit. A polarity bit chooses between an active-low line, which is the default, and an active-high line.

Top module: `uart_rx_fifo`

## Requirements
- R1: Accepted words leave in arrival order. There are 8 entries. `rd_valid` is high while `level` is nonzero, and `rd_data` shows the oldest word. Each `pop` with a nonzero level removes one word at the clock edge. A `pop` while empty has no effect. `level` changes by the number of words accepted minus the number removed in that cycle.
- R2: With `thr_sel`=0, `count_stat` is 1 exactly while `level` >= 4. With `thr_sel`=1, it is 1 exactly while `level` >= 7. It falls without any host action once reads take the level below the threshold.
- R3: `rx_busy` goes to 1 on the edge after `start_det` and to 0 on the edge after `frame_done`. If both occur in the same cycle, `start_det` wins.
- R4: A `frame_done` that arrives while `level` is 8 is an overrun. This holds even if `pop` is high in the same cycle. The word is discarded, the stored contents stay as they are, and `ovr_flag` becomes 1 on the next edge. `ovr_flag` stays 1 until a cycle with `ovr_clr`=1, which clears it on the next edge. A new overrun in that same cycle wins over the clear.
- R5: With `auto_rts`=1, request-to-send is withdrawn from the edge after a `start_det` seen while `level` >= W, and stays withdrawn while `level` >= W. W is 2 when `rts_sel`=0 and 4 when `rts_sel`=1. Filling past W without a further start bit does not withdraw it.
- R6: With `auto_rts`=1, request-to-send is granted again in the same cycle in which `level` drops below W. It stays granted until the next qualifying `start_det`.
- R7: With `auto_rts`=0, request-to-send is granted exactly while `manual_rts`=1. `rts_out` is the inverse of the granted state when `rts_pol`=0 (active low) and equal to it when `rts_pol`=1.
- R8: `rd_addr` is the address bit (`rx_addr`) that was stored with the word currently at the head. It is meaningful while `rd_valid`=1.
- R9: `addr_sticky` becomes 1 on the edge after an accepted word with `rx_addr`=1. It stays 1 until a cycle with `sticky_clr`=1, and a new address word in that same cycle wins over the clear. A word discarded by an overrun does not set it.
- R10: After reset the buffer is empty, `count_stat`, `rx_busy`, `ovr_flag` and `addr_sticky` are 0, and the automatic request-to-send is in the granted state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_det | input | 1 | Pulse: start transition detected |
| frame_done | input | 1 | Pulse: first stop bit sampled, word valid |
| rx_data | input | DW | Received word |
| rx_addr | input | 1 | Address bit of the received word |
| pop | input | 1 | Host removes the head word |
| thr_sel | input | 1 | Threshold select: 0 for 4 words, 1 for 7 words |
| rts_sel | input | 1 | Watermark select: 0 for 2 words, 1 for 4 words |
| auto_rts | input | 1 | 1: automatic request-to-send |
| manual_rts | input | 1 | Grant request-to-send in manual mode |
| rts_pol | input | 1 | 0: active-low line, 1: active-high line |
| ovr_clr | input | 1 | Write-1 clear of the overrun flag |
| sticky_clr | input | 1 | Write-1 clear of the sticky address flag |
| rd_data | output | DW | Head word |
| rd_addr | output | 1 | Address bit of the head word |
| rd_valid | output | 1 | Buffer not empty |
| level | output | CW | Number of words held |
| count_stat | output | 1 | Threshold count status |
| rx_busy | output | 1 | Reception in progress |
| ovr_flag | output | 1 | Sticky overrun |
| addr_sticky | output | 1 | Sticky address-word flag |
| rts_out | output | 1 | Request-to-send line |

## Verification
The bench goes after three kinds of corner case. The first is a word that arrives at a full buffer, including arrivals in the same cycle as a pop. A design that stores the word or moves a pointer there corrupts the head order or lets `level` pass 8. The second is the hysteresis of request-to-send: the level climbs past the watermark with no new start bit, or sits at it while a start bit arrives. A design without the start-bit qualification withdraws the line too early, and one that re-grants on a registered copy of the level lags by a cycle. The third is a set and a clear of a sticky flag in the same cycle, where the set must win. The bench also checks that the address bit stays with its own entry, so a design that reports the address bit of the latest word shows the wrong value at the head.

// File: rtl/uart_rx_fifo.sv
module uart_rx_fifo #(
  parameter int DW    = 8,
  parameter int DEPTH = 8,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_det,
  input  logic          frame_done,
  input  logic [DW-1:0] rx_data,
  input  logic          rx_addr,
  input  logic          pop,
  input  logic          thr_sel,
  input  logic          rts_sel,
  input  logic          auto_rts,
  input  logic          manual_rts,
  input  logic          rts_pol,
  input  logic          ovr_clr,
  input  logic          sticky_clr,
  output logic [DW-1:0] rd_data,
  output logic          rd_addr,
  output logic          rd_valid,
  output logic [CW-1:0] level,
  output logic          count_stat,
  output logic          rx_busy,
  output logic          ovr_flag,
  output logic          addr_sticky,
  output logic          rts_out
);
  localparam int AW = $clog2(DEPTH);

  logic [DW:0]   mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic          hold;

  wire full  = (level == CW'(DEPTH));
  wire push  = frame_done & ~full;
  wire take  = pop & rd_valid;
  wire [CW-1:0] wmark = rts_sel ? CW'(4) : CW'(2);
  wire [CW-1:0] thr   = thr_sel ? CW'(7) : CW'(4);
  wire above = (level >= wmark);
  wire grant = auto_rts ? ~(hold & above) : manual_rts;

  assign rd_valid   = (level != '0);
  assign {rd_addr, rd_data} = mem[rp];
  assign count_stat = (level >= thr);
  assign rts_out    = rts_pol ? grant : ~grant;

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= {rx_addr, rx_data};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp <= '0;
      rp <= '0;
      level <= '0;
      rx_busy <= 1'b0;
      ovr_flag <= 1'b0;
      addr_sticky <= 1'b0;
      hold <= 1'b0;
    end else begin
      if (push) wp <= wp + AW'(1);
      if (take) rp <= rp + AW'(1);
      level <= level + CW'(push) - CW'(take);
      if (start_det)       rx_busy <= 1'b1;
      else if (frame_done) rx_busy <= 1'b0;
      if (frame_done & full) ovr_flag <= 1'b1;
      else if (ovr_clr)      ovr_flag <= 1'b0;
      if (push & rx_addr)  addr_sticky <= 1'b1;
      else if (sticky_clr) addr_sticky <= 1'b0;
      if (!auto_rts)              hold <= 1'b0;
      else if (start_det & above) hold <= 1'b1;
      else if (!above)            hold <= 1'b0;
    end
  end
endmodule

// File: rtl/uart_rx_fifo_chk.sv
module uart_rx_fifo_chk #(
  parameter int CW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start_det,
  input logic          frame_done,
  input logic          rx_addr,
  input logic          pop,
  input logic          ovr_clr,
  input logic          sticky_clr,
  input logic [CW-1:0] level,
  input logic          rx_busy,
  input logic          ovr_flag,
  input logic          addr_sticky
);
  assert_level_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
    level <= CW'(8));

  assert_pop_only_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && level != '0 && !frame_done) |=> level == $past(level) - CW'(1));

  assert_busy_rise_R3: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> rx_busy);

  assert_busy_fall_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done && !start_det) |=> !rx_busy);

  assert_overrun_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done && level == CW'(8)) |=> ovr_flag);

  assert_overrun_discard_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done && level == CW'(8) && !pop) |=> level == CW'(8));

  assert_ovr_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_flag && !ovr_clr) |=> ovr_flag);

  assert_sticky_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done && rx_addr && level < CW'(8)) |=> addr_sticky);

  assert_sticky_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_sticky && !sticky_clr) |=> addr_sticky);
endmodule

bind uart_rx_fifo uart_rx_fifo_chk #(.CW(CW)) u_chk (.*);

// File: tb/sim_uart_rx_fifo.sv
module sim_uart_rx_fifo;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_det = 0, frame_done = 0, rx_addr = 0, pop = 0;
  logic [7:0] rx_data = 0;
  logic thr_sel = 0, rts_sel = 0, auto_rts = 0, manual_rts = 0, rts_pol = 0;
  logic ovr_clr = 0, sticky_clr = 0;
  logic [7:0] rd_data;
  logic rd_addr, rd_valid, count_stat, rx_busy, ovr_flag, addr_sticky, rts_out;
  logic [3:0] level;

  always #10 clk = ~clk;

  uart_rx_fifo u0 (.*);

  int vecs = 0, errs = 0;
  int qd[$];
  int qa[$];
  bit m_busy = 0, m_ovr = 0, m_stk = 0, m_hold = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    vecs++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int wmk();
    return rts_sel ? 4 : 2;
  endfunction

  function automatic bit exp_rts();
    bit g;
    g = auto_rts ? !(m_hold && qd.size() >= wmk()) : manual_rts;
    return rts_pol ? g : !g;
  endfunction

  task automatic model_edge();
    int n = qd.size();
    bit full = (n == 8);
    bit pu = frame_done && !full;
    bit po = pop && n > 0;
    if (!auto_rts) m_hold = 0;
    else if (start_det && n >= wmk()) m_hold = 1;
    else if (n < wmk()) m_hold = 0;
    if (start_det) m_busy = 1; else if (frame_done) m_busy = 0;
    if (frame_done && full) m_ovr = 1; else if (ovr_clr) m_ovr = 0;
    if (pu && rx_addr) m_stk = 1; else if (sticky_clr) m_stk = 0;
    if (po) begin void'(qd.pop_front()); void'(qa.pop_front()); end
    if (pu) begin qd.push_back(rx_data); qa.push_back(rx_addr); end
  endtask

  task automatic compare();
    int n = qd.size();
    chk(level == n, "R1 level", level, n);
    chk(rd_valid == (n > 0), "R1 rd_valid", rd_valid, n > 0);
    if (n > 0) begin
      chk(rd_data == qd[0], "R1 head data", rd_data, qd[0]);
      chk(rd_addr == qa[0], "R8 head addr", rd_addr, qa[0]);
    end
    chk(count_stat == (n >= (thr_sel ? 7 : 4)), "R2 count_stat", count_stat, n >= (thr_sel ? 7 : 4));
    chk(rx_busy == m_busy, "R3 rx_busy", rx_busy, m_busy);
    chk(ovr_flag == m_ovr, "R4 ovr_flag", ovr_flag, m_ovr);
    chk(addr_sticky == m_stk, "R9 addr_sticky", addr_sticky, m_stk);
    chk(rts_out == exp_rts(), auto_rts ? "R5 R6 rts_out" : "R7 rts_out", rts_out, exp_rts());
  endtask

  task automatic step(input bit s, input bit f, input bit p, input bit a,
                      input bit oc = 0, input bit sc = 0);
    start_det = s; frame_done = f; pop = p; rx_addr = a;
    rx_data = 8'($urandom); ovr_clr = oc; sticky_clr = sc;
    @(posedge clk);
    model_edge();
    @(negedge clk);
    compare();
    // R6: rts re-grant is combinational on level; check after input change too
    start_det = 0; frame_done = 0; pop = 0; ovr_clr = 0; sticky_clr = 0;
    #1 chk(rts_out == exp_rts(), "R6 rts_out idle", rts_out, exp_rts());
  endtask

  initial begin
    #(20 * 150000);
    errs++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    // R10 reset state
    chk(level == 0 && !rd_valid, "R10 empty", level, 0);
    chk(!count_stat && !rx_busy && !ovr_flag && !addr_sticky, "R10 flags",
        {count_stat, rx_busy, ovr_flag, addr_sticky}, 0);
    rst_n = 1;
    @(negedge clk);
    // R10: auto rts granted after reset (active low -> 0)
    auto_rts = 1;
    #1 chk(rts_out == 1'b0, "R10 rts granted", rts_out, 0);

    // R5/R6 directed: watermark 2
    step(0, 1, 0, 1); step(0, 1, 0, 0); step(0, 1, 0, 0);
    chk(rts_out == 1'b0, "R5 no start no drop", rts_out, 0);
    step(1, 0, 0, 0);
    chk(rts_out == 1'b1, "R5 dropped", rts_out, 1);
    step(0, 0, 1, 0); step(0, 0, 1, 0);
    chk(rts_out == 1'b0, "R6 regranted", rts_out, 0);
    // R9: same-cycle set and clear -> set wins
    step(0, 1, 0, 1, 0, 1);
    chk(addr_sticky == 1'b1, "R9 set wins", addr_sticky, 1);
    step(0, 0, 0, 0, 0, 1);
    // R4: fill to full, overrun with pop and clear in same cycle
    for (int i = 0; i < 10; i++) step(0, 1, 0, i[0]);
    step(0, 1, 1, 1, 1, 1);
    chk(ovr_flag == 1'b1, "R4 overrun set wins", ovr_flag, 1);
    step(0, 0, 0, 0, 1, 0);
    chk(ovr_flag == 1'b0, "R4 cleared", ovr_flag, 0);
    // R1: pop while empty
    for (int i = 0; i < 10; i++) step(0, 0, 1, 0);
    chk(level == 0, "R1 empty pop", level, 0);
    // R3: start and frame_done same cycle
    step(1, 1, 0, 0);
    chk(rx_busy == 1'b1, "R3 start wins", rx_busy, 1);

    for (int c = 0; c < 6000; c++) begin
      int ph = (c / 200) % 3;
      int pf = (ph == 0) ? 60 : (ph == 1) ? 15 : 35;
      int pp = (ph == 0) ? 15 : (ph == 1) ? 60 : 35;
      if (c % 150 == 0) begin
        thr_sel = 1'($urandom); rts_sel = 1'($urandom);
        auto_rts = ($urandom % 4) != 0; rts_pol = 1'($urandom);
      end
      manual_rts = ($urandom % 8) == 0 ? ~manual_rts : manual_rts;
      step(($urandom % 100) < 30, ($urandom % 100) < pf, ($urandom % 100) < pp,
           ($urandom % 4) == 0, ($urandom % 20) == 0, ($urandom % 20) == 0);
    end
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule